// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block sits between a host and a battery-backed static memory and decides, one clock at a time, whether the memory may be touched. It receives three digital supply-level flags, each reporting that the supply is above one of three thresholds: a high level (about 3.0 V), a middle level (about 2.8 V) and a low level (about 2.5 V). Each flag passes through its own deglitch filter. A four-state controller then locks writes, floats the data bus, picks the memory supply (external or battery) and reports whether the backup cell has been armed.

The host's select, write and read requests reach the memory only in the normal operating state. A falling supply locks the memory when the middle flag drops. The battery is switched in below the low flag. On the way back up, the external supply returns at the low flag, but normal access resumes only at the high flag. After reset the backup cell stays sealed (disconnected) until the supply is first seen above the high level. From then on it stays armed.

Top module: `pwr_guard`

## Requirements
- R1: A supply flag is acted on only after its new level has been sampled on STABLE_CYCLES consecutive clock edges (default 4). A pulse that lasts fewer edges has no effect on any output.
- R2: During and right after reset, the state is SEALED, wr_lock=1, dq_hiz=1, bat_sel=0, bat_armed=0, and all memory strobes are 0.
- R3: SEALED is left only for NORMAL, and only when the filtered high flag is 1. While SEALED, bat_sel stays 0 even when the low flag drops.
- R4: bat_armed becomes 1 on leaving SEALED and stays 1 until the next reset.
- R5: In NORMAL, a filtered middle flag of 0 with the low flag still 1 moves the state to PROTECT, which raises wr_lock. A drop of the high flag alone keeps NORMAL.
- R6: In any armed state, a filtered low flag of 0 moves the state to BATTERY, which raises bat_sel. This takes priority over the middle-flag rule.
- R7: From BATTERY, a filtered low flag of 1 moves the state to PROTECT. bat_sel drops and wr_lock stays 1.
- R8: From PROTECT, the state returns to NORMAL only when the filtered high flag is 1. The low and middle flags alone do not resume access.
- R9: In NORMAL, mem_sel = host_sel, mem_wr = host_sel & host_wr, and mem_rd = host_sel & host_rd & !host_wr. dq_hiz = !mem_rd, so a write overrides a read.
- R10: In every state other than NORMAL, mem_sel, mem_wr and mem_rd are 0 and dq_hiz is 1, whatever the host drives. A write held across the loss of NORMAL is cut in the same cycle the state changes.
- R11: state_o reports SEALED=2'b00, NORMAL=2'b01, PROTECT=2'b10, BATTERY=2'b11. wr_lock is 1 exactly when state_o is not NORMAL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sup_above_hi | input | 1 | Supply above high threshold (about 3.0 V) |
| sup_above_mid | input | 1 | Supply above middle threshold (about 2.8 V) |
| sup_above_lo | input | 1 | Supply above low threshold (about 2.5 V) |
| host_sel | input | 1 | Host memory select request |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| mem_sel | output | 1 | Gated select to memory |
| mem_wr | output | 1 | Gated write strobe to memory |
| mem_rd | output | 1 | Gated read/output enable to memory |
| dq_hiz | output | 1 | Data bus held high-impedance |
| wr_lock | output | 1 | Write protection active |
| bat_sel | output | 1 | Memory supplied from battery |
| bat_armed | output | 1 | Backup cell connected (seal broken) |
| state_o | output | 2 | Controller state code |

## Verification
The assertions check on every cycle that strobes stay quiet outside NORMAL, that reads and writes never reach the memory together, and that the battery stays deselected while sealed. They also check that the armed flag never clears and that the legal state successors hold. Only the bench's scenarios can show the timing: the deglitch length, glitch rejection on each flag, the hysteresis between the 2.8 V lock and the 3.0 V resume, and the direct fall into BATTERY when two flags drop together. A cycle-level reference model compares every output on every clock while these scenarios run.

// File: rtl/pwr_guard_pkg.sv
// Package: shared state encoding and supply-flag indices for the supervisor.
// Assumes the flag vector is ordered low, middle, high (bits 0..2).
package pwr_guard_pkg;
    typedef enum logic [1:0] {
        ST_SEALED  = 2'b00,
        ST_NORMAL  = 2'b01,
        ST_PROTECT = 2'b10,
        ST_BATTERY = 2'b11
    } pg_state_e;

    localparam int SENSE_LO  = 0;
    localparam int SENSE_MID = 1;
    localparam int SENSE_HI  = 2;
    localparam int NUM_SENSE = 3;
endpackage

// File: rtl/pg_deglitch.sv
// Module: pg_deglitch
// Filters one supply-level flag. The output follows the raw input only
// after the raw level has differed from the output on STABLE consecutive
// clock edges. Assumes STABLE >= 1; the output resets to 0 (below threshold).
module pg_deglitch #(
    parameter int STABLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = (STABLE < 2) ? 1 : $clog2(STABLE + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive samples that disagree with the filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_o  <= 1'b0;
            run_cnt <= '0;
        end else if (raw_i != filt_o) begin
            if (run_cnt == LAST) begin
                filt_o  <= raw_i;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end
endmodule

// File: rtl/pg_fsm.sv
// Module: pg_fsm
// Four-state supply controller. It moves between sealed, normal, protected
// and battery states from the filtered flags and decodes the lock, battery
// select and armed outputs from the state register. Assumes the flags
// are already deglitched.
module pg_fsm
    import pwr_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ok_hi,
    input  logic      ok_mid,
    input  logic      ok_lo,
    output pg_state_e state_q,
    output logic      lock_o,
    output logic      bat_sel_o,
    output logic      armed_o
);
    pg_state_e state_d;

    // Next-state selection; the low flag takes priority over the middle flag.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEALED:  if (ok_hi) state_d = ST_NORMAL;
            ST_NORMAL: begin
                if (!ok_lo)       state_d = ST_BATTERY;
                else if (!ok_mid) state_d = ST_PROTECT;
            end
            ST_PROTECT: begin
                if (!ok_lo)      state_d = ST_BATTERY;
                else if (ok_hi)  state_d = ST_NORMAL;
            end
            ST_BATTERY: if (ok_lo) state_d = ST_PROTECT;
            default:    state_d = ST_SEALED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SEALED;
        else        state_q <= state_d;
    end

    // Output decode from the registered state.
    always_comb begin
        lock_o    = (state_q != ST_NORMAL);
        bat_sel_o = (state_q == ST_BATTERY);
        armed_o   = (state_q != ST_SEALED);
    end
endmodule

// File: rtl/pg_gate.sv
// Module: pg_gate
// Combinational strobe gate. It passes host requests to the memory only in
// the normal state. A write masks a read, and the bus floats unless a read
// is driven. Since it is combinational, a write is cut in the same cycle
// the state leaves normal.
module pg_gate
    import pwr_guard_pkg::*;
(
    input  pg_state_e state_i,
    input  logic      host_sel,
    input  logic      host_wr,
    input  logic      host_rd,
    output logic      mem_sel,
    output logic      mem_wr,
    output logic      mem_rd,
    output logic      dq_hiz
);
    logic access_ok;

    // Qualify each host strobe with the access permission.
    always_comb begin
        access_ok = (state_i == ST_NORMAL);
        mem_sel   = access_ok & host_sel;
        mem_wr    = access_ok & host_sel & host_wr;
        mem_rd    = access_ok & host_sel & host_rd & ~host_wr;
        dq_hiz    = ~mem_rd;
    end
endmodule

// File: rtl/pwr_guard.sv
// Module: pwr_guard (top)
// Power-fail write-protect supervisor for a battery-backed static memory.
// It deglitches three supply flags, runs the state controller and gates
// the host strobes. Assumes the flags are synchronous to clk.
module pwr_guard
    import pwr_guard_pkg::*;
#(
    parameter int STABLE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_above_hi,
    input  logic       sup_above_mid,
    input  logic       sup_above_lo,
    input  logic       host_sel,
    input  logic       host_wr,
    input  logic       host_rd,
    output logic       mem_sel,
    output logic       mem_wr,
    output logic       mem_rd,
    output logic       dq_hiz,
    output logic       wr_lock,
    output logic       bat_sel,
    output logic       bat_armed,
    output logic [1:0] state_o
);
    logic [NUM_SENSE-1:0] raw_flags;
    logic [NUM_SENSE-1:0] filt_flags;
    pg_state_e            cur_state;

    // Pack the raw flags into index order.
    always_comb begin
        raw_flags[SENSE_LO]  = sup_above_lo;
        raw_flags[SENSE_MID] = sup_above_mid;
        raw_flags[SENSE_HI]  = sup_above_hi;
    end

    for (genvar g = 0; g < NUM_SENSE; g++) begin : g_filter
        pg_deglitch #(.STABLE(STABLE_CYCLES)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_flags[g]),
            .filt_o (filt_flags[g])
        );
    end

    pg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ok_hi     (filt_flags[SENSE_HI]),
        .ok_mid    (filt_flags[SENSE_MID]),
        .ok_lo     (filt_flags[SENSE_LO]),
        .state_q   (cur_state),
        .lock_o    (wr_lock),
        .bat_sel_o (bat_sel),
        .armed_o   (bat_armed)
    );

    pg_gate u_gate (
        .state_i  (cur_state),
        .host_sel (host_sel),
        .host_wr  (host_wr),
        .host_rd  (host_rd),
        .mem_sel  (mem_sel),
        .mem_wr   (mem_wr),
        .mem_rd   (mem_rd),
        .dq_hiz   (dq_hiz)
    );

    // Expose the state code.
    always_comb state_o = cur_state;
endmodule

// File: rtl/pwr_guard_chk.sv
// Module: pwr_guard_chk
// Port-level checker bound into pwr_guard. It watches the strobe gating,
// the battery and seal flags, and the legal state successors.
module pwr_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_sel,
    input logic       mem_wr,
    input logic       mem_rd,
    input logic       dq_hiz,
    input logic       wr_lock,
    input logic       bat_sel,
    input logic       bat_armed,
    input logic [1:0] state_o
);
    AST_QUIET_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'b01) |-> (!mem_sel && !mem_wr && !mem_rd && dq_hiz)); // R10
    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd) && (dq_hiz != mem_rd)); // R9
    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bat_armed |=> bat_armed); // R4
    AST_SEALED_NO_BATTERY: assert property (@(posedge clk) disable iff (!rst_n)
        !bat_armed |-> !bat_sel); // R3
    AST_SEALED_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00) |=> (state_o == 2'b00 || state_o == 2'b01)); // R3
    AST_BATTERY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b11) |=> (state_o == 2'b11 || state_o == 2'b10)); // R7
    AST_LOCK_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lock == (state_o != 2'b01)); // R11
endmodule

bind pwr_guard pwr_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_sel   (mem_sel),
    .mem_wr    (mem_wr),
    .mem_rd    (mem_rd),
    .dq_hiz    (dq_hiz),
    .wr_lock   (wr_lock),
    .bat_sel   (bat_sel),
    .bat_armed (bat_armed),
    .state_o   (state_o)
);

// File: tb/pwr_guard_bench.sv
// Bench for pwr_guard. A behavioural cycle model is compared on every
// clock, and directed checks run at the scenario milestones.
module pwr_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STABLE     = 4;
    localparam int SETTLE     = STABLE + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi = 1'b0, mid = 1'b0, lo = 1'b0;
    logic hsel = 1'b0, hwr = 1'b0, hrd = 1'b0;
    logic mem_sel, mem_wr, mem_rd, dq_hiz, wr_lock, bat_sel, bat_armed;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state.
    int m_st = 0;
    int m_cnt [3];
    bit m_filt [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_guard #(.STABLE_CYCLES(STABLE)) u_pwr_guard (
        .clk(clk), .rst_n(rst_n),
        .sup_above_hi(hi), .sup_above_mid(mid), .sup_above_lo(lo),
        .host_sel(hsel), .host_wr(hwr), .host_rd(hrd),
        .mem_sel(mem_sel), .mem_wr(mem_wr), .mem_rd(mem_rd), .dq_hiz(dq_hiz),
        .wr_lock(wr_lock), .bat_sel(bat_sel), .bat_armed(bat_armed),
        .state_o(state_o)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Reference model: the state advances on the old filtered levels,
    // then each filter takes its new sample.
    always @(posedge clk) begin
        bit raw [3];
        raw[0] = lo; raw[1] = mid; raw[2] = hi;
        if (!rst_n) begin
            m_st = 0;
            for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_filt[i] = 0; end
        end else begin
            case (m_st)
                0: if (m_filt[2]) m_st = 1;
                1: if (!m_filt[0]) m_st = 3; else if (!m_filt[1]) m_st = 2;
                2: if (!m_filt[0]) m_st = 3; else if (m_filt[2]) m_st = 1;
                default: if (m_filt[0]) m_st = 2;
            endcase
            for (int i = 0; i < 3; i++) begin
                if (raw[i] != m_filt[i]) begin
                    m_cnt[i]++;
                    if (m_cnt[i] >= STABLE) begin m_filt[i] = raw[i]; m_cnt[i] = 0; end
                end else m_cnt[i] = 0;
            end
        end
    end

    // Compare every output shortly after each falling edge.
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done) begin
            bit ok;
            int e_rd;
            ok = (m_st == 1);
            e_rd = ok & hsel & hrd & ~hwr;
            check("R11", "state", state_o, m_st);
            check(ok ? "R9" : "R10", "mem_sel", mem_sel, ok & hsel);
            check(ok ? "R9" : "R10", "mem_wr", mem_wr, ok & hsel & hwr);
            check(ok ? "R9" : "R10", "mem_rd", mem_rd, e_rd);
            check(ok ? "R9" : "R10", "dq_hiz", dq_hiz, !e_rd);
            check("R5", "wr_lock", wr_lock, !ok);
            check("R6", "bat_sel", bat_sel, m_st == 3);
            check("R4", "bat_armed", bat_armed, m_st != 0);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_state(string tag, int code);
        #2;
        check(tag, "directed state", state_o, code);
    endtask

    initial begin
        step(3);
        #2;
        check("R2", "reset state", state_o, 0);
        check("R2", "reset lock", wr_lock, 1);
        check("R2", "reset hiz", dq_hiz, 1);
        check("R2", "reset bat_sel", bat_sel, 0);
        check("R2", "reset armed", bat_armed, 0);
        step(1); rst_n = 1'b1;
        // Still sealed with the low and middle flags up; the low flag then drops.
        lo = 1; mid = 1;
        step(SETTLE); expect_state("R3", 0);
        step(1); lo = 0;
        step(SETTLE); expect_state("R3", 0);
        check("R3", "sealed bat_sel", bat_sel, 0);
        step(1); lo = 1;
        step(SETTLE);
        // A glitch on the high flag one edge short of the filter length.
        step(1); hi = 1;
        step(STABLE - 1); hi = 0;
        step(SETTLE); expect_state("R1", 0);
        // A real power-up.
        step(1); hi = 1;
        step(SETTLE); expect_state("R3", 1);
        check("R4", "armed after power-up", bat_armed, 1);
        // Host traffic in NORMAL.
        step(1); hsel = 1; hwr = 1;
        step(1); hwr = 0; hrd = 1;
        step(1); #2; check("R9", "read drives bus", dq_hiz, 0);
        step(1); hwr = 1;
        step(1); #2; check("R9", "write masks read", mem_rd, 0);
        step(1); hsel = 0;
        step(2); hsel = 1; hwr = 1; hrd = 0;
        // A short glitch on the middle flag has no effect.
        step(1); mid = 0;
        step(STABLE - 1); mid = 1;
        step(SETTLE); expect_state("R1", 1);
        // High flag drop alone keeps NORMAL (hysteresis).
        step(1); hi = 0;
        step(SETTLE); expect_state("R5", 1);
        // Middle drop with a write held: lock and cut.
        step(1); mid = 0;
        step(SETTLE); expect_state("R5", 2);
        check("R10", "write cut", mem_wr, 0);
        // Low drop: battery.
        step(1); lo = 0;
        step(SETTLE); expect_state("R6", 3);
        check("R6", "battery selected", bat_sel, 1);
        // Low returns: back to external supply, still locked.
        step(1); lo = 1;
        step(SETTLE); expect_state("R7", 2);
        check("R7", "lock held", wr_lock, 1);
        // Middle returns alone: no resume.
        step(1); mid = 1;
        step(SETTLE); expect_state("R8", 2);
        // High returns: resume.
        step(1); hi = 1;
        step(SETTLE); expect_state("R8", 1);
        check("R4", "armed persists", bat_armed, 1);
        // Low and middle drop together: straight to BATTERY.
        step(1); lo = 0; mid = 0; hi = 0;
        step(SETTLE); expect_state("R6", 3);
        step(1); lo = 1; mid = 1; hi = 1;
        step(SETTLE + 2); expect_state("R8", 1);
        step(1); hsel = 0; hwr = 0;
        step(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: run did not complete got 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule